// File: doc/BRIEF.md
# Dual-View Video Splitter

This block takes a single video stream whose frames hold two images side by side or stacked by line, and divides it into two independent output streams, A and B. Every accepted input beat carries a pixel word together with horizontal sync, vertical sync and data-enable levels. Each beat is forwarded, with its sync and data-enable levels unchanged, to exactly one of the two outputs. The sync timing seen on each output is therefore rebuilt from the beats that output receives.

Two routing modes exist. In column mode, consecutive beats alternate between A and B, blanking beats included, so each output gets half of every line at half the input pixel rate. The first active pixel of each line always goes to A. In row mode, whole lines alternate: the first line after a vertical sync goes to A, the next to B, and so on. The mode input is only taken into account at the start of a frame, and a line whose horizontal total is odd raises a status bit.

The input side has a beat qualifier `in_valid` and no ready signal. Video cannot be stalled, so the block accepts a beat in every cycle in which `in_valid` is high. Each output presents a one-cycle `*_valid` strobe per forwarded beat, and the downstream logic must take it in that cycle. A cycle in which `*_valid` is high acts as that output's pixel enable.

Top module: `dv_splitter`

## Requirements
- R1: After reset, `a_valid`, `b_valid` and `err_odd_htotal` are 0, and the routing mode is column mode (encoding 0) until the first vertical-sync start.
- R2: Each cycle with `in_valid`=1 produces, one cycle later, a strobe on exactly one of `a_valid`/`b_valid`. The strobed output carries that beat's data, hs, vs and de unchanged. A cycle with `in_valid`=0 produces no strobe on either output one cycle later.
- R3: In column mode, a beat with de=1 whose previous accepted beat had de=0 (a line start) goes to A. From there, accepted beats alternate B, A, B, … blanking included, until the next line start.
- R4: The column-mode alternation is not reset by hs or by cycles with `in_valid`=0. Only a line start (R3) restarts it.
- R5: In row mode, a beat with hs=1 whose previous accepted beat had hs=0 starts a new line. Every beat of a line goes to the same output, and successive lines alternate between A and B.
- R6: A beat with vs=1 whose previous accepted beat had vs=0 (a frame start) restarts the row count. In row mode that beat and the rest of its line go to A.
- R7: `mode_sel` (0 = column, 1 = row) is sampled only on a frame-start beat. It applies from that beat on, and changes at any other time have no effect on routing.
- R8: On each hs-rising beat after the first since reset, `err_odd_htotal` takes the value 1 if the number of accepted beats in the line just completed is odd, else 0. The new value appears one cycle later and is held between hs-rising beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Requested mode: 0 column, 1 row; sampled at frame start |
| in_valid | input | 1 | Input beat qualifier; accepted every cycle it is high |
| in_data | input | DATA_W | Input pixel word |
| in_hs | input | 1 | Input horizontal sync level |
| in_vs | input | 1 | Input vertical sync level |
| in_de | input | 1 | Input data-enable level |
| a_valid | output | 1 | Stream A beat strobe (pixel enable) |
| a_data | output | DATA_W | Stream A pixel word |
| a_hs | output | 1 | Stream A horizontal sync |
| a_vs | output | 1 | Stream A vertical sync |
| a_de | output | 1 | Stream A data enable |
| b_valid | output | 1 | Stream B beat strobe (pixel enable) |
| b_data | output | DATA_W | Stream B pixel word |
| b_hs | output | 1 | Stream B horizontal sync |
| b_vs | output | 1 | Stream B vertical sync |
| b_de | output | 1 | Stream B data enable |
| err_odd_htotal | output | 1 | Last completed line had an odd beat count |

## Verification
All results are due exactly one cycle after the beat that causes them. The output strobe and its data and sync fields follow the accepted beat by one cycle. The odd-total flag follows the hs-rising beat that closes a line by one cycle. The bench drives one beat per falling edge. At the next falling edge it compares both outputs and the flag against a model that it advanced on the previous beat, so every comparison lands on the cycle in which the registered result becomes visible. Idle cycles are mixed in so that the absence of a strobe is checked as well.

// File: rtl/dv_split_pkg.sv
package dv_split_pkg;

  typedef enum logic {
    DV_COLUMN = 1'b0,
    DV_ROW    = 1'b1
  } dv_mode_e;

  typedef struct packed {
    logic hs;
    logic vs;
    logic de;
  } dv_sync_t;

endpackage

// File: rtl/dv_edge_track.sv
module dv_edge_track
  import dv_split_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     beat,
  input  dv_sync_t sync,
  output logic     hs_rise,
  output logic     vs_rise,
  output logic     de_rise
);

  dv_sync_t last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (beat) begin
      last_q <= sync;
    end
  end

  always_comb begin
    hs_rise = sync.hs && !last_q.hs;
    vs_rise = sync.vs && !last_q.vs;
    de_rise = sync.de && !last_q.de;
  end

endmodule

// File: rtl/dv_route_ctrl.sv
module dv_route_ctrl
  import dv_split_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     beat,
  input  logic     hs_rise,
  input  logic     vs_rise,
  input  logic     de_rise,
  input  logic     mode_sel,
  output dv_mode_e eff_mode,
  output logic     to_b
);

  dv_mode_e cur_mode_q;
  logic     col_par_q;   // 1: next column beat goes to B
  logic     row_par_q;   // 1: current line belongs to B
  logic     col_b;
  logic     row_b;

  always_comb begin
    eff_mode = vs_rise ? dv_mode_e'(mode_sel) : cur_mode_q;
    col_b    = de_rise ? 1'b0 : col_par_q;
    if (vs_rise)      row_b = 1'b0;
    else if (hs_rise) row_b = !row_par_q;
    else              row_b = row_par_q;
    to_b = (eff_mode == DV_ROW) ? row_b : col_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_mode_q <= DV_COLUMN;
      col_par_q  <= 1'b0;
      row_par_q  <= 1'b0;
    end else if (beat) begin
      cur_mode_q <= eff_mode;
      col_par_q  <= !col_b;
      row_par_q  <= row_b;
    end
  end

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat && vs_rise) |=> $stable(cur_mode_q)); // R7

  AST_COL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !de_rise) |=> (col_par_q != $past(col_par_q))); // R4

endmodule

// File: rtl/dv_htotal_check.sv
module dv_htotal_check #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  input  logic hs_rise,
  output logic err_odd
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      err_odd <= 1'b0;
    end else if (beat) begin
      if (hs_rise) begin
        if (seen_q) err_odd <= cnt_q[0];
        cnt_q  <= CNT_W'(1);
        seen_q <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat && hs_rise) |=> $stable(err_odd)); // R8

endmodule

// File: rtl/dv_out_stage.sv
module dv_out_stage
  import dv_split_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] data_in,
  input  dv_sync_t          sync_in,
  output logic              valid_out,
  output logic [DATA_W-1:0] data_out,
  output dv_sync_t          sync_out
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_out <= 1'b0;
      data_out  <= '0;
      sync_out  <= '0;
    end else begin
      valid_out <= take;
      if (take) begin
        data_out <= data_in;
        sync_out <= sync_in;
      end
    end
  end

endmodule

// File: rtl/dv_splitter.sv
module dv_splitter
  import dv_split_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_hs,
  input  logic              in_vs,
  input  logic              in_de,
  output logic              a_valid,
  output logic [DATA_W-1:0] a_data,
  output logic              a_hs,
  output logic              a_vs,
  output logic              a_de,
  output logic              b_valid,
  output logic [DATA_W-1:0] b_data,
  output logic              b_hs,
  output logic              b_vs,
  output logic              b_de,
  output logic              err_odd_htotal
);

  localparam int N_OUT = 2;

  dv_sync_t    in_sync;
  logic        hs_rise, vs_rise, de_rise;
  dv_mode_e    eff_mode;
  logic        to_b;
  logic        o_valid [N_OUT];
  logic [DATA_W-1:0] o_data [N_OUT];
  dv_sync_t    o_sync  [N_OUT];

  assign in_sync = '{hs: in_hs, vs: in_vs, de: in_de};

  dv_edge_track u_edges (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (in_valid),
    .sync    (in_sync),
    .hs_rise (hs_rise),
    .vs_rise (vs_rise),
    .de_rise (de_rise)
  );

  dv_route_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat     (in_valid),
    .hs_rise  (hs_rise),
    .vs_rise  (vs_rise),
    .de_rise  (de_rise),
    .mode_sel (mode_sel),
    .eff_mode (eff_mode),
    .to_b     (to_b)
  );

  dv_htotal_check #(.CNT_W(CNT_W)) u_htot (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat    (in_valid),
    .hs_rise (hs_rise),
    .err_odd (err_odd_htotal)
  );

  for (genvar s = 0; s < N_OUT; s++) begin : g_out
    dv_out_stage #(.DATA_W(DATA_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (in_valid && (to_b == 1'(s))),
      .data_in   (in_data),
      .sync_in   (in_sync),
      .valid_out (o_valid[s]),
      .data_out  (o_data[s]),
      .sync_out  (o_sync[s])
    );
  end

  assign a_valid = o_valid[0];
  assign a_data  = o_data[0];
  assign a_hs    = o_sync[0].hs;
  assign a_vs    = o_sync[0].vs;
  assign a_de    = o_sync[0].de;
  assign b_valid = o_valid[1];
  assign b_data  = o_data[1];
  assign b_hs    = o_sync[1].hs;
  assign b_vs    = o_sync[1].vs;
  assign b_de    = o_sync[1].de;

  AST_ONE_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (a_valid != b_valid)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!a_valid && !b_valid)); // R2

  AST_DATA_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((a_valid ? a_data : b_data) == $past(in_data))); // R2

  AST_LINE_START_A: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && de_rise && eff_mode == DV_COLUMN) |=> a_valid); // R3

  AST_FRAME_START_A: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && vs_rise && mode_sel) |=> a_valid); // R6

endmodule

// File: tb/tb_dv_splitter.sv
module tb_dv_splitter;

  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_hs = 1'b0, in_vs = 1'b0, in_de = 1'b0;
  logic a_valid, a_hs, a_vs, a_de, b_valid, b_hs, b_vs, b_de, err_odd_htotal;
  logic [DW-1:0] a_data, b_data;

  int n_checks = 0;
  int n_fail = 0;

  // bench model state
  logic m_phs = 0, m_pvs = 0, m_pde = 0;
  logic m_mode = 0, m_col = 0, m_row = 0;
  logic m_seen = 0, m_err = 0;
  int   m_cnt = 0;
  logic e_va = 0, e_vb = 0;
  logic [DW-1:0] e_data = '0;
  logic e_hs = 0, e_vs = 0, e_de = 0;
  int   gap_ctr = 0;
  logic [DW-1:0] pix = '0;

  always #2.5 clk = ~clk;

  dv_splitter #(.DATA_W(DW), .CNT_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
    .in_data(in_data), .in_hs(in_hs), .in_vs(in_vs), .in_de(in_de),
    .a_valid(a_valid), .a_data(a_data), .a_hs(a_hs), .a_vs(a_vs), .a_de(a_de),
    .b_valid(b_valid), .b_data(b_data), .b_hs(b_hs), .b_vs(b_vs), .b_de(b_de),
    .err_odd_htotal(err_odd_htotal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare outputs with the expectation of the previous cycle's beat
  task automatic compare_out();
    logic [DW-1:0] got;
    logic [2:0] gsync;
    chk("R2 strobes", {30'd0, a_valid, b_valid}, {30'd0, e_va, e_vb});
    if (e_va || e_vb) begin
      got   = e_va ? a_data : b_data;
      gsync = e_va ? {a_hs, a_vs, a_de} : {b_hs, b_vs, b_de};
      chk("R2/R3/R5 beat fields", {21'd0, got, gsync}, {21'd0, e_data, e_hs, e_vs, e_de});
    end
    chk("R8 odd total flag", {31'd0, err_odd_htotal}, {31'd0, m_err});
  endtask

  // one cycle: check previous result, then drive and model a new beat
  task automatic cycle(input logic v, input logic hs, input logic vs, input logic de);
    logic hr, vr, dr, mode_now, col_b, row_b, tb_b;
    @(negedge clk);
    compare_out();
    in_valid = v; in_hs = hs; in_vs = vs; in_de = de; in_data = pix;
    e_va = 0; e_vb = 0;
    if (v) begin
      hr = hs && !m_phs; vr = vs && !m_pvs; dr = de && !m_pde;
      mode_now = vr ? mode_sel : m_mode;
      col_b = dr ? 1'b0 : m_col;
      row_b = vr ? 1'b0 : (hr ? !m_row : m_row);
      tb_b  = mode_now ? row_b : col_b;
      e_va = !tb_b; e_vb = tb_b;
      e_data = pix; e_hs = hs; e_vs = vs; e_de = de;
      m_mode = mode_now; m_col = !col_b; m_row = row_b;
      m_phs = hs; m_pvs = vs; m_pde = de;
      if (hr) begin
        if (m_seen) m_err = m_cnt[0];
        m_cnt = 1; m_seen = 1;
      end else begin
        m_cnt++;
      end
      pix = pix + 8'd7;
    end
  endtask

  // beat with an idle cycle ahead of it every fifth call
  task automatic beat(input logic hs, input logic vs, input logic de);
    gap_ctr++;
    if (gap_ctr % 5 == 0) cycle(1'b0, 1'b0, 1'b0, 1'b0);
    cycle(1'b1, hs, vs, de);
  endtask

  // frame: 6 lines, hs on beats 0..1, de on beats 3..ht-2 for lines 2..5,
  // vs on lines 0..1; mode_sel flipped to flip_to at the middle of line 3
  task automatic frame(input int ht, input logic flip_to);
    for (int ln = 0; ln < 6; ln++) begin
      for (int bx = 0; bx < ht; bx++) begin
        if (ln == 3 && bx == ht / 2) mode_sel = flip_to;
        beat(bx < 2, ln < 2, (ln >= 2) && (bx >= 3) && (bx <= ht - 2));
      end
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    chk("R1 reset", {29'd0, a_valid, b_valid, err_odd_htotal}, 32'd0);
    // R1/R3/R4/R7: column mode from reset, request for row ignored mid-frame
    mode_sel = 1'b0;
    frame(10, 1'b1);
    // R5/R6/R7: row mode picked up at this frame start
    frame(10, 1'b1);
    // R8: odd horizontal total in row mode, switch back requested mid-frame
    frame(11, 1'b0);
    // R3/R4/R8: column mode again, even total clears the flag
    frame(10, 1'b0);
    frame(9, 1'b1);
    frame(10, 1'b1);
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule